// File: doc/BRIEF.md
# Dual-Pattern Moore Sequence Detector

This block watches a serial bit stream, one bit per clock, and raises a single flag when the last three bits it took in form either `110` or `101`. Occurrences may overlap. The tail of one match can be the head of the next, so each such occurrence is reported.

The block is a Moore machine. The flag is decoded from the registered state alone and never comes straight from the input. It is therefore high for exactly the clock cycle that follows the edge at which the final bit of a pattern was sampled. The machine has six states, all of them needed, and keeps them in a 3-bit binary register. The two unused codes lead back to idle.

A synchronous reset returns the machine to idle, where the flag is low. Bits sampled before the reset do not count toward a later match.

Top module: `dual_pattern_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the machine goes to idle. From the next cycle on, `det_o` is 0, whatever `din` carries during reset.
- R2: When the three bits sampled at the three latest non-reset edges are 1, 1, 0 (oldest first), `det_o` is 1 in the cycle after the third edge.
- R3: When the three bits sampled at the three latest non-reset edges are 1, 0, 1 (oldest first), `det_o` is 1 in the cycle after the third edge.
- R4: Overlap between the two patterns is detected. For the stream 1,1,0,1, `det_o` is 1 after both the third bit and the fourth bit.
- R5: In any cycle whose three latest sampled bits match neither pattern, `det_o` is 0. This includes cycles in which fewer than three bits have been sampled since reset.
- R6: `det_o` depends only on the state. It does not change while `din` changes between clock edges.
- R7: A pattern can overlap with itself. The stream 1,0,1,0,1 gives `det_o` = 0,0,1,0,1 after its successive bits.
- R8: Bits sampled before a reset do not take part in any match. After 1,1 then a reset then 0, `det_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input bit, sampled at each rising edge |
| det_o | output | 1 | Match flag, decoded from the state |

## Verification
Two things can happen in the same cycle. The flag can be high for a completed `110` while the bit sampled at that same edge continues a `101` whose first two bits are the `10` just matched. A completed `101` can likewise also be the start of another `101`. Directed streams such as 1101 and 10101 provoke these cases. An exhaustive sweep of every 8-bit stream after reset, together with a long pseudo-random stream, covers them as well. Every cycle is judged against a 3-bit shift-history model in the bench, whose match result is compared one cycle after the bit enters.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int STATE_W = 3;
  localparam int HIST_W  = 3;

  // State codes (binary); 6 and 7 are unused
  localparam logic [STATE_W-1:0] ST_IDLE   = 3'd0; // nothing useful seen
  localparam logic [STATE_W-1:0] ST_ONE    = 3'd1; // ends in lone 1
  localparam logic [STATE_W-1:0] ST_ONEONE = 3'd2; // ends in 11
  localparam logic [STATE_W-1:0] ST_ONEZRO = 3'd3; // ends in 10, no match
  localparam logic [STATE_W-1:0] ST_HIT110 = 3'd4; // just matched 110
  localparam logic [STATE_W-1:0] ST_HIT101 = 3'd5; // just matched 101

  function automatic logic state_legal(input logic [STATE_W-1:0] s);
    return (s <= ST_HIT101);
  endfunction

  // Transition function of the reduced machine
  function automatic logic [STATE_W-1:0] step_state(
    input logic [STATE_W-1:0] cur,
    input logic               b
  );
    case (cur)
      ST_IDLE:   return b ? ST_ONE    : ST_IDLE;
      ST_ONE:    return b ? ST_ONEONE : ST_ONEZRO;
      ST_ONEONE: return b ? ST_ONEONE : ST_HIT110;
      ST_ONEZRO: return b ? ST_HIT101 : ST_IDLE;
      ST_HIT110: return b ? ST_HIT101 : ST_IDLE;
      ST_HIT101: return b ? ST_ONEONE : ST_ONEZRO;
      default:   return ST_IDLE;
    endcase
  endfunction

  // Flag decode: a function of state only
  function automatic logic state_flag(input logic [STATE_W-1:0] s);
    return (s == ST_HIT110) || (s == ST_HIT101);
  endfunction

  // Pattern test on a bit history, oldest bit in the MSB
  function automatic logic hist_match(input logic [HIST_W-1:0] h);
    return (h == 3'b110) || (h == 3'b101);
  endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  logic [STATE_W-1:0] cur_state,
  input  logic               bit_in,
  output logic [STATE_W-1:0] nxt_state
);

  always_comb begin
    nxt_state = step_state(cur_state, bit_in);
  end

endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STATE_W-1:0] nxt_state,
  output logic [STATE_W-1:0] state_q
);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= nxt_state;
  end

  // R1
  rst_to_idle_chk: assert property (@(posedge clk) rst |=> (state_q == ST_IDLE));

  // R5
  legal_state_chk: assert property (@(posedge clk) disable iff (rst)
    state_legal(state_q));

endmodule

// File: rtl/seqdet_decode.sv
module seqdet_decode
  import seqdet_pkg::*;
(
  input  logic [STATE_W-1:0] state_q,
  output logic               flag,
  output logic               hit_110,
  output logic               hit_101
);

  always_comb begin
    hit_110 = (state_q == ST_HIT110);
    hit_101 = (state_q == ST_HIT101);
    flag    = state_flag(state_q);
  end

endmodule

// File: rtl/dual_pattern_detector.sv
module dual_pattern_detector
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic det_o
);

  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] nxt_state;
  logic               hit_110;
  logic               hit_101;

  seqdet_next u_next (
    .cur_state (state_q),
    .bit_in    (din),
    .nxt_state (nxt_state)
  );

  seqdet_state_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .state_q   (state_q)
  );

  seqdet_decode u_dec (
    .state_q (state_q),
    .flag    (det_o),
    .hit_110 (hit_110),
    .hit_101 (hit_101)
  );

  // Count of bits taken since reset, saturating at the history depth
  logic [1:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst)                seen_q <= 2'd0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end

  // R2
  hit_110_chk: assert property (@(posedge clk) disable iff (rst)
    hit_110 |-> ($past(din, 3) && $past(din, 2) && !$past(din)));

  // R3
  hit_101_chk: assert property (@(posedge clk) disable iff (rst)
    hit_101 |-> ($past(din, 3) && !$past(din, 2) && $past(din)));

  // R4
  overlap_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_110 && din) |=> hit_101);

  // R5
  history_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q == 2'd3) |-> (det_o == hist_match({$past(din, 3), $past(din, 2), $past(din)})));

  // R8
  fresh_chk: assert property (@(posedge clk) disable iff (rst)
    det_o |-> (seen_q == 2'd3));

endmodule

// File: tb/test_dual_pattern_detector.sv
module test_dual_pattern_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic det_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [2:0] hist = 3'b000;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk; // 125 MHz

  dual_pattern_detector i_dual_pattern_detector (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .det_o (det_o)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: det_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge: hold reset for n edges
  task automatic do_reset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      din = ~din;
      @(posedge clk);
      @(negedge clk);
      check(det_o, 1'b0, "R1");
    end
    rst  = 1'b0;
    hist = 3'b000;
  endtask

  // Called at a negedge: feed one bit, check the flag one cycle on
  task automatic feed(input logic b, input string req);
    logic exp;
    string tag;
    din = b;
    @(posedge clk);
    hist = {hist[1:0], b};
    exp  = (hist == 3'b110) || (hist == 3'b101);
    @(negedge clk);
    if (req != "") tag = req;
    else if (hist == 3'b110) tag = "R2";
    else if (hist == 3'b101) tag = "R3";
    else tag = "R5";
    check(det_o, exp, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(3);

    // R4: 1101 -> 0,0,1,1
    feed(1'b1, "R4"); feed(1'b1, "R4"); feed(1'b0, "R4"); feed(1'b1, "R4");

    // R7: 10101 -> 0,0,1,0,1
    do_reset(1);
    feed(1'b1, "R7"); feed(1'b0, "R7"); feed(1'b1, "R7"); feed(1'b0, "R7"); feed(1'b1, "R7");

    // R8: 1,1, reset, 0 -> no match
    do_reset(1);
    feed(1'b1, "R8"); feed(1'b1, "R8");
    do_reset(1);
    feed(1'b0, "R8");
    feed(1'b1, "R8");

    // R1: pattern shown during reset has no effect
    rst = 1'b1;
    din = 1'b1; @(posedge clk); @(negedge clk); check(det_o, 1'b0, "R1");
    din = 1'b1; @(posedge clk); @(negedge clk); check(det_o, 1'b0, "R1");
    din = 1'b0; @(posedge clk); @(negedge clk); check(det_o, 1'b0, "R1");
    rst = 1'b0; hist = 3'b000;

    // R2 R3 R5: every 8-bit stream after reset
    for (int v = 0; v < 256; v++) begin
      do_reset(1);
      for (int k = 7; k >= 0; k--) feed(v[k], "");
    end

    // R6: long stream, din toggled mid-cycle must not move det_o
    do_reset(1);
    for (int n = 0; n < 2000; n++) begin
      logic held;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      feed(lfsr[0], "");
      held = det_o;
      din = ~din;
      #1;
      check(det_o, held, "R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule